// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM. The memory has a 21-bit address, an 8-bit data bus (split here into an output path, an output-enable and an input path), a low-active and a high-active chip select, a low-active output enable and a low-active write enable. The host offers one single-beat request at a time over a valid/ready handshake (address, write flag, write byte). A read returns its byte with a one-clock response pulse. Every memory timing limit is a nanosecond parameter that is converted to clock cycles by rounding up, so the same controller serves any clock rate.

A state machine sequences the strobes. States: `ST_IDLE` (memory deselected, ready once the power-up hold-off has run out), `ST_RD_SETUP` and `ST_RD_WAIT` (read strobes held for the read window), `ST_RD_CAPTURE` (memory deselected, response pulse), `ST_TURNAROUND` (write held back until the memory has released the bus), `ST_WR_SETUP` (selected, data driven, write strobe high), `ST_WR_PULSE` (write strobe low) and `ST_WR_RECOVER` (write strobe high again, still selected). Transitions: IDLE to RD_SETUP on an accepted read; IDLE to WR_SETUP on an accepted write when the bus is free, otherwise IDLE to TURNAROUND; TURNAROUND to WR_SETUP once the bus-release timer has expired; RD_SETUP to RD_WAIT unconditionally; RD_WAIT to RD_CAPTURE when the phase timer expires (the byte is sampled on that edge); RD_CAPTURE to IDLE; WR_SETUP to WR_PULSE; WR_PULSE to WR_RECOVER and WR_RECOVER to IDLE, each when the phase timer expires.

With the default 8 ns clock the read window is 9 cycles, the write pulse 7 cycles, the recovery 1 cycle, the bus release 4 cycles and the power-up hold-off 12500 cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, the memory is deselected: mem_sel_n=1, mem_sel=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R2: After reset is released, req_ready stays low for exactly ceil(T_BOOT_NS/CLK_NS) rising edges (12500 by default) and is high from then on whenever the controller is idle.
- R3: A read holds mem_sel_n=0, mem_sel=1, mem_oe_n=0 and mem_we_n=1 with mem_dq_oe=0 for exactly the read window of ceil(max(read cycle, address access, select access, output-enable access)/CLK_NS) cycles, 9 by default.
- R4: The read byte is taken from mem_dq_in on the edge that closes the last cycle of the read window; rsp_valid is then high for exactly one clock with that byte on rsp_rdata, while the memory is deselected.
- R5: A write holds the memory selected with mem_oe_n=1 for one setup cycle with mem_we_n=1, then mem_we_n=0 for ceil(max(pulse width, data setup, select-to-end minus one cycle, address-to-end minus one cycle)/CLK_NS) cycles (7 by default), then one or more recovery cycles with mem_we_n=1 still selected; 9 selected cycles in total by default, with mem_dq_oe=1 throughout.
- R6: Every write ends with mem_we_n rising while both chip selects are still active, and the byte on mem_dq_out at that edge is the one stored at mem_addr.
- R7: After mem_oe_n rises, mem_dq_oe does not rise until mem_oe_n has been high for at least ceil(T_HZ_NS/CLK_NS) full cycles (4 by default); a write requested straight after a read passes through ST_TURNAROUND.
- R8: mem_dq_oe is never high while mem_oe_n is low.
- R9: A request presented while req_ready is low causes no memory activity: the memory stays deselected.
- R10: Address and write byte are captured when a request is accepted; changing req_addr or req_wdata afterwards does not affect the access, and mem_addr and mem_dq_out stay stable while the memory is selected or driven.
- R11: rsp_rdata keeps the last read byte until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, low active |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock pulse when a read byte is ready |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 21 | Address pins of the memory |
| mem_sel_n | output | 1 | Chip select, low active |
| mem_sel | output | 1 | Chip select, high active |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_dq_out | output | 8 | Byte driven toward the memory data pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte read from the memory data pins |

## Verification
The hardest situation to reach is the bus turnaround: a write has to arrive while the memory may still be driving the data pins after a read, and it only exists if the host issues the write in the very cycles after the response pulse. The bench issues a write immediately after a read completes and measures, at the pins, how many cycles the output enable has been high when the controller starts driving. A memory model that returns a poison byte until the full read window has passed, and that stores only when the write strobe rises while still selected, exposes early sampling and a write ended by the chip selects.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctl_state_e;

    // Nanoseconds to whole clock cycles, rounding up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, floored at zero.
    function automatic int unsigned usub(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_boot_hold.sv
module sram_boot_hold #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned BW = $clog2(HOLD_CYC + 1);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= BW'(HOLD_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - BW'(1);
        end
    end

    assign done = (left_q == '0);
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 21,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_ACE_NS  = 70,
    parameter int unsigned T_DOE_NS  = 35,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_PWE_NS  = 45,
    parameter int unsigned T_SCE_NS  = 60,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_HZ_NS   = 25,
    parameter int unsigned T_BOOT_NS = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Cycle counts derived from the nanosecond limits.
    localparam int unsigned RD_CYC = umax(2, umax(umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                                  umax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS))));
    localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned PW_CYC = umax(1, umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                                  umax(usub(ns_to_cyc(T_SCE_NS, CLK_NS), 1),
                                                       usub(ns_to_cyc(T_AW_NS, CLK_NS), 1))));
    localparam int unsigned REC_CYC  = umax(1, usub(WC_CYC, 1 + PW_CYC));
    localparam int unsigned HZ_CYC   = umax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
    localparam int unsigned BOOT_CYC = umax(1, ns_to_cyc(T_BOOT_NS, CLK_NS));
    localparam int unsigned TMR_MAX  = umax(umax(RD_CYC, PW_CYC), umax(REC_CYC, HZ_CYC));
    localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);

    ctl_state_e state_q, state_d;

    logic              boot_done;
    logic              ph_load, ph_expired;
    logic [TMR_W-1:0]  ph_val;
    logic              bus_load, bus_idle;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    sram_boot_hold #(.HOLD_CYC(BOOT_CYC)) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (boot_done)
    );

    // Times the phases of the current access.
    sram_phase_timer #(.W(TMR_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    // Times the memory's release of the data pins after a read.
    sram_phase_timer #(.W(TMR_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bus_load),
        .load_val (TMR_W'(HZ_CYC)),
        .expired  (bus_idle)
    );

    assign accept = req_valid && req_ready;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loads.
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        bus_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)    state_d = ST_RD_SETUP;
                    else if (bus_idle) state_d = ST_WR_SETUP;
                    else               state_d = ST_TURNAROUND;
                end
            end
            ST_RD_SETUP: begin
                state_d = ST_RD_WAIT;
                ph_load = 1'b1;
                ph_val  = TMR_W'(RD_CYC - 2);
            end
            ST_RD_WAIT: begin
                if (ph_expired) begin
                    state_d  = ST_RD_CAPTURE;
                    bus_load = 1'b1;
                end
            end
            ST_RD_CAPTURE: begin
                state_d = ST_IDLE;
            end
            ST_TURNAROUND: begin
                if (bus_idle) state_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                ph_load = 1'b1;
                ph_val  = TMR_W'(PW_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (ph_expired) begin
                    state_d = ST_WR_RECOVER;
                    ph_load = 1'b1;
                    ph_val  = TMR_W'(REC_CYC - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (ph_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and read sampling.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_RD_WAIT && ph_expired) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_sel_n = 1'b1;
        mem_sel   = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        rsp_valid = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = boot_done;
            end
            ST_RD_SETUP, ST_RD_WAIT: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_RD_CAPTURE: begin
                rsp_valid = 1'b1;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_TURNAROUND: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

    // ---------------- assertions ----------------
    logic [TMR_W:0] we_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         we_low_cnt <= '0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else                we_low_cnt <= '0;
    end

    // R5: write strobe low for exactly the computed pulse length
    a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == (TMR_W+1)'(PW_CYC)));

    // R6: write ends on the write strobe, both selects still active
    a_r6_we_ends_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_sel_n && mem_sel));

    // R7: drive starts only after the release interval has run out
    a_r7_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> bus_idle);

    // R8: no drive while the memory output is enabled
    a_r8_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R1, R2: ready only after the hold-off, with the memory deselected
    a_r2_ready_after_boot: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (boot_done && mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R4: response is a single-clock pulse
    a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: address stable while selected, data stable while driven
    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

    a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;

    localparam int CLK_NS = 8;
    localparam int RD_E   = (70 + CLK_NS - 1) / CLK_NS;      // read window
    localparam int PW_E   = (60 + CLK_NS - 1) / CLK_NS - 1;  // write pulse
    localparam int WSEL_E = 1 + PW_E + 1;                    // selected write cycles
    localparam int HZ_E   = (25 + CLK_NS - 1) / CLK_NS;      // bus release
    localparam int BOOT_E = (100000 + CLK_NS - 1) / CLK_NS;  // power-up hold-off

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [20:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [20:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // ---------------- memory model and pin monitor ----------------
    logic [7:0] model_mem [int];
    logic [7:0] ref_mem [int];
    int rd_run = 0, rd_age = 0, last_rd_len = 0;
    int we_run = 0, last_we_len = 0;
    int wsel_run = 0, last_wsel_len = 0;
    int oe_gap = 1000, last_dq_gap = 0;
    int fight = 0;
    bit prev_dq_oe = 0;
    logic [7:0] dq_drv = 8'hEE;

    function automatic logic [7:0] model_rd(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        bit sel_on, rd_on;
        sel_on = !mem_sel_n && mem_sel;
        rd_on  = sel_on && !mem_oe_n && mem_we_n;
        if (rd_on) begin
            rd_run++; rd_age++;
        end else begin
            if (rd_run != 0) last_rd_len = rd_run;
            rd_run = 0; rd_age = 0;
        end
        dq_drv = (rd_on && rd_age >= RD_E) ? model_rd(int'(mem_addr)) : 8'hEE;
        if (!mem_we_n) begin
            we_run++;
        end else begin
            if (we_run != 0) begin
                last_we_len = we_run;
                if (sel_on) model_mem[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : 8'hEE;
            end
            we_run = 0;
        end
        if (sel_on && mem_oe_n) wsel_run++;
        else begin
            if (wsel_run != 0) last_wsel_len = wsel_run;
            wsel_run = 0;
        end
        if (!mem_oe_n) oe_gap = 0;
        else if (oe_gap < 1000) oe_gap++;
        if (mem_dq_oe && !prev_dq_oe) last_dq_gap = oe_gap;
        prev_dq_oe = mem_dq_oe;
        if (mem_dq_oe && !mem_oe_n) fight++;
    end

    assign mem_dq_in = dq_drv;

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe, req,
            {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    endtask

    task automatic issue(input bit wr, input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_boot();
        int busy = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset strobes");
        chk(!req_ready && !rsp_valid, "R2 reset ready/rsp", {req_ready, rsp_valid}, 0);
        rst_n = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h00055; req_wdata = 8'h99;
        for (int k = 1; k < BOOT_E; k++) begin
            @(negedge clk);
            if (!mem_sel_n || mem_sel || req_ready) busy++;
        end
        req_valid = 1'b0;
        chk(busy == 0, "R9 request during hold-off", busy, 0);
        chk(!req_ready, "R2 ready low at last hold-off cycle", req_ready, 0);
        @(negedge clk);
        chk(req_ready, "R2 ready after hold-off", req_ready, 1);
        @(negedge clk);
        chk_idle("R9 no access after hold-off");
    endtask

    task automatic t_write(input logic [20:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        ref_mem[int'(a)] = d;
        wait_idle();
        chk(last_we_len == PW_E, "R5 write pulse length", last_we_len, PW_E);
        chk(last_wsel_len == WSEL_E, "R5 selected write cycles", last_wsel_len, WSEL_E);
        chk(model_rd(int'(a)) == d, "R6 byte stored at strobe end", model_rd(int'(a)), d);
        chk_idle("R1 idle after write");
    endtask

    task automatic t_read(input logic [20:0] a);
        int n = 0;
        logic [7:0] exp;
        exp = ref_rd(int'(a));
        issue(1'b0, a, 8'h00);
        while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
        chk(rsp_valid, "R4 response seen", rsp_valid, 1);
        chk(rsp_rdata == exp, "R4 read byte", rsp_rdata, exp);
        chk_idle("R4 deselected during response");
        @(negedge clk);
        chk(!rsp_valid, "R4 single-clock response", rsp_valid, 0);
        chk(rsp_rdata == exp, "R11 byte held", rsp_rdata, exp);
        chk(last_rd_len == RD_E, "R3 read window length", last_rd_len, RD_E);
    endtask

    task automatic t_write_after_read();
        t_read(21'h00100);
        t_write(21'h00101, 8'h3C);
        chk(last_dq_gap >= HZ_E + 1, "R7 drive after release", last_dq_gap, HZ_E + 1);
        t_read(21'h00101);
    endtask

    task automatic t_inputs_after_accept();
        issue(1'b1, 21'h0ABCD, 8'h5A);
        req_addr = 21'h0ABCE; req_wdata = 8'hA5;
        ref_mem[int'(21'h0ABCD)] = 8'h5A;
        wait_idle();
        chk(model_rd(int'(21'h0ABCD)) == 8'h5A, "R10 captured write byte",
            model_rd(int'(21'h0ABCD)), 8'h5A);
        chk(!model_mem.exists(int'(21'h0ABCE)), "R10 later address ignored",
            int'(model_mem.exists(int'(21'h0ABCE))), 0);
        t_read(21'h0ABCD);
    endtask

    task automatic t_patterns();
        t_write(21'h000000, 8'h01);
        t_write(21'h1FFFFF, 8'hFE);
        t_write(21'h155555, 8'hAA);
        t_write(21'h0AAAAA, 8'h55);
        t_read(21'h1FFFFF);
        t_read(21'h000000);
        t_read(21'h0AAAAA);
        t_read(21'h155555);
        t_read(21'h012345);
        t_write(21'h000000, 8'h80);
        t_read(21'h000000);
    endtask

    // ---------------- sequence and watchdog ----------------
    initial begin
        t_reset_boot();
        t_patterns();
        t_write_after_read();
        t_inputs_after_accept();
        chk(fight == 0, "R8 drive while output enabled", fight, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule